// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character into a serial frame each time it is asked to. The frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line idles high. The format is chosen at run time: 5 to 9 data bits, no parity, even parity or odd parity, and one or two stop bits. The block captures the format together with the data word when it accepts a start strobe.

Each frame bit stays on the line for one bit period. In asynchronous mode an external bit-clock enable marks the end of each period. In synchronous mode the block watches an external shift clock instead. The polarity bit picks whether the output changes after a rising edge or after a falling edge of that clock. A busy flag covers the whole frame, and a one-cycle done pulse marks the return to idle.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is high and `busy` is low.
- R2: A `start` pulse while not busy is accepted. In the next cycle `busy` is high and `txd` is low, which is the start bit.
- R3: Data bits follow the start bit with the least significant bit first. `size_code` gives the data bit count: 3'b000=5, 3'b001=6, 3'b010=7, 3'b011=8, 3'b111=9. The reserved codes 3'b100, 3'b101 and 3'b110 give 8 data bits.
- R4: `par_code` 2'b10 appends an even-parity bit and 2'b11 appends an odd-parity bit, placed right after the last data bit. Even parity makes the number of ones over the data bits and the parity bit even; odd parity makes it odd. Codes 2'b00 and the reserved 2'b01 send no parity bit.
- R5: `two_stop`=0 ends the frame with one high stop bit, and `two_stop`=1 ends it with two.
- R6: In asynchronous mode (`sync_mode`=0), a frame bit is held until a cycle in which `bit_tick` is high. The next bit appears in the following cycle. `sclk` and `sclk_pol` have no effect in this mode.
- R7: In synchronous mode (`sync_mode`=1), the frame advances once for each active `sclk` edge. An edge is detected when `sclk` differs from its value in the previous clock cycle. The active edge is rising when `sclk_pol`=0 and falling when `sclk_pol`=1. `bit_tick` is ignored in this mode.
- R8: A `start` pulse while `busy` is high is ignored and does not disturb the frame in progress.
- R9: When the last stop bit's period ends, `busy` falls and `done` is high for exactly one cycle.
- R10: Data, format, mode and polarity are captured when a frame is accepted. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send one character |
| data | input | 9 | Character to send, least significant bit first |
| size_code | input | 3 | Data bit count code |
| par_code | input | 2 | Parity mode code |
| two_stop | input | 1 | Two stop bits when high |
| sync_mode | input | 1 | Selects the shift clock (1) or the bit-clock enable (0) |
| sclk_pol | input | 1 | Active shift clock edge in synchronous mode: 0 rising, 1 falling |
| bit_tick | input | 1 | Bit period enable for asynchronous mode |
| sclk | input | 1 | External shift clock for synchronous mode |
| txd | output | 1 | Serial data line |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
Every size code, including the three reserved ones, is sent with data whose high bits are set. A frame that is too short or too long then shows up as a wrong bit count on the line, not just a shifted pattern. The parity codes are tried on data with both even and odd numbers of ones, which tells even parity from odd parity and from the reserved no-parity code. Asynchronous frames are sent while the shift clock toggles at random, and synchronous frames of both polarities are sent while `bit_tick` toggles at random, so that listening to the wrong step source is caught. Some frames get extra start pulses or changed configuration partway through, to show that the frame in progress is undisturbed.

// File: rtl/sft_pkg.sv
package sft_pkg;
  parameter int DATA_W   = 9;
  parameter int STOP_MAX = 2;
  localparam int FRAME_W = 1 + DATA_W + 1 + STOP_MAX;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // Data bit count for a size code; reserved codes fall back to 8.
  function automatic int unsigned size_to_bits(input logic [2:0] code);
    case (code)
      3'b000:  return 5;
      3'b001:  return 6;
      3'b010:  return 7;
      3'b011:  return 8;
      3'b111:  return 9;
      default: return 8;
    endcase
  endfunction

  // Parity present only for codes 2'b10 and 2'b11.
  function automatic logic parity_enabled(input logic [1:0] code);
    return code[1];
  endfunction

  // Parity bit over the low n bits; odd=1 makes the total number of ones odd.
  function automatic logic parity_bit(input logic [DATA_W-1:0] d,
                                      input int unsigned n, input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(n)) p = p ^ d[i];
    return p;
  endfunction
endpackage

// File: rtl/sft_frame_build.sv
module sft_frame_build
  import sft_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int FW = FRAME_W,
  parameter int CW = CNT_W
) (
  input  logic [DW-1:0] data,
  input  logic [2:0]    size_code,
  input  logic [1:0]    par_code,
  input  logic          two_stop,
  output logic [FW-1:0] frame,
  output logic [CW-1:0] last_idx
);
  int unsigned nbits;
  logic        pen;
  logic        pbit;

  always_comb begin
    nbits = size_to_bits(size_code);
    pen   = parity_enabled(par_code);
    pbit  = parity_bit(data, nbits, par_code[0]);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (i < int'(nbits)) frame[i+1] = data[i];
    if (pen) frame[nbits+1] = pbit;
    last_idx = CW'(nbits + 32'(pen) + 32'(two_stop) + 1);
  end
endmodule

// File: rtl/sft_step_gen.sv
module sft_step_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic bit_tick,
  input  logic use_sclk,
  input  logic fall_edge,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic step
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  assign step = use_sclk ? (fall_edge ? sclk_fall : sclk_rise) : bit_tick;
endmodule

// File: rtl/sft_serializer.sv
module sft_serializer #(
  parameter int FW = 13,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic [FW-1:0] frame_in,
  input  logic [CW-1:0] last_in,
  output logic          accept,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  logic [FW-1:0] frame_q;
  logic [CW-1:0] last_q;
  logic [CW-1:0] idx;
  logic [CW-1:0] idx_nx;
  logic          at_end;

  assign accept = start & ~busy;
  assign idx_nx = idx + 1'b1;
  assign at_end = (idx == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      last_q  <= '0;
      idx     <= '0;
      txd     <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        frame_q <= frame_in;
        last_q  <= last_in;
        idx     <= '0;
        busy    <= 1'b1;
        txd     <= frame_in[0];
      end else if (busy && step) begin
        if (at_end) begin
          busy <= 1'b0;
          done <= 1'b1;
          txd  <= 1'b1;
        end else begin
          idx <= idx_nx;
          txd <= frame_q[idx_nx];
        end
      end
    end
  end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic [2:0]        size_code,
  input  logic [1:0]        par_code,
  input  logic              two_stop,
  input  logic              sync_mode,
  input  logic              sclk_pol,
  input  logic              bit_tick,
  input  logic              sclk,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  logic [FRAME_W-1:0] frame_w;
  logic [CNT_W-1:0]   last_w;
  logic               accept_w;
  logic               step_w;
  logic               sclk_rise_w;
  logic               sclk_fall_w;
  logic               mode_q;
  logic               pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (accept_w) begin
      mode_q <= sync_mode;
      pol_q  <= sclk_pol;
    end
  end

  sft_frame_build #(.DW(DATA_W), .FW(FRAME_W), .CW(CNT_W)) u_build (
    .data(data), .size_code(size_code), .par_code(par_code),
    .two_stop(two_stop), .frame(frame_w), .last_idx(last_w)
  );

  sft_step_gen u_step (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .bit_tick(bit_tick),
    .use_sclk(mode_q), .fall_edge(pol_q),
    .sclk_rise(sclk_rise_w), .sclk_fall(sclk_fall_w), .step(step_w)
  );

  sft_serializer #(.FW(FRAME_W), .CW(CNT_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step_w),
    .frame_in(frame_w), .last_in(last_w), .accept(accept_w),
    .txd(txd), .busy(busy), .done(done)
  );
endmodule

// File: rtl/sft_checker.sv
module sft_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic txd,
  input logic busy,
  input logic done,
  input logic step
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !txd));

  assert_hold_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step && !start) |=> (busy && $stable(txd)));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step) |=> (busy && $stable(txd)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind serial_frame_tx sft_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .txd(txd),
  .busy(busy), .done(done), .step(step_w)
);

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] data = '0;
  logic [2:0] size_code = '0;
  logic [1:0] par_code = '0;
  logic       two_stop = 1'b0;
  logic       sync_mode = 1'b0;
  logic       sclk_pol = 1'b0;
  logic       bit_tick = 1'b0;
  logic       sclk = 1'b0;
  logic       txd, busy, done;

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  string tag = "R1";

  bit m_busy = 0, m_done = 0, m_txd = 1, m_sync = 0, m_pol = 0, m_prev = 0;
  bit q[$];

  always #5 clk = ~clk;

  serial_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .data(data),
    .size_code(size_code), .par_code(par_code), .two_stop(two_stop),
    .sync_mode(sync_mode), .sclk_pol(sclk_pol), .bit_tick(bit_tick),
    .sclk(sclk), .txd(txd), .busy(busy), .done(done)
  );

  // Reference model: the frame is a queue of bits still to send after the start bit.
  always @(posedge clk) begin
    bit stp;
    int n, ones;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_txd = 1; m_sync = 0; m_pol = 0; m_prev = 0;
      q.delete();
    end else begin
      if (m_sync) stp = m_pol ? (m_prev && !sclk) : (!m_prev && sclk);
      else        stp = bit_tick;
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          if (size_code == 3'b111) n = 9;
          else if (size_code[2])   n = 8;
          else                     n = 5 + int'(size_code[1:0]);
          q.delete();
          ones = 0;
          for (int i = 0; i < n; i++) begin
            q.push_back(data[i]);
            if (data[i]) ones++;
          end
          if (par_code == 2'b10) q.push_back(ones % 2 == 1);
          if (par_code == 2'b11) q.push_back(ones % 2 == 0);
          q.push_back(1'b1);
          if (two_stop) q.push_back(1'b1);
          m_busy = 1; m_txd = 0; m_sync = sync_mode; m_pol = sclk_pol;
        end
      end else if (stp) begin
        if (q.size() == 0) begin
          m_busy = 0; m_done = 1; m_txd = 1;
        end else begin
          m_txd = q.pop_front();
        end
      end
      m_prev = sclk;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (txd !== m_txd || busy !== m_busy || done !== m_done) begin
        miscompares++;
        $display("FAIL %s t=%0t txd/busy/done actual=%b%b%b expected=%b%b%b",
                 tag, $time, txd, busy, done, m_txd, m_busy, m_done);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // extra: 0 none, 1 restart pulses mid-frame (R8), 2 config change mid-frame (R10)
  task automatic send(input logic [8:0] d, input logic [2:0] sz, input logic [1:0] pc,
                      input logic ts, input logic sm, input logic pol,
                      input string t, input int extra);
    int ph;
    @(negedge clk);
    tag = t;
    data = d; size_code = sz; par_code = pc; two_stop = ts;
    sync_mode = sm; sclk_pol = pol; start = 1'b1;
    ph = 0;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      if (c > 0 && m_done) break;
      start = 1'b0;
      if (extra == 1 && (c == 4 || c == 11)) begin
        start = 1'b1;
        data = ~d;
      end
      if (extra == 2 && c == 5) begin
        data = ~d; size_code = 3'b000; par_code = ~pc; two_stop = ~ts;
        sync_mode = ~sm; sclk_pol = ~pol;
      end
      if (sm) begin
        bit_tick = 1'($urandom);
        ph++;
        if (ph == 2) begin sclk = ~sclk; ph = 0; end
      end else begin
        sclk = 1'($urandom);
        bit_tick = (c % 3 == 2);
      end
    end
    start = 1'b0; bit_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    repeat (4) @(negedge clk);
    send(9'h0A5, 3'b011, 2'b00, 1'b0, 1'b0, 1'b0, "R2", 0);
    // R3: every size code, high data bits set
    for (int s = 0; s < 8; s++)
      send(9'h1FF ^ 9'(s * 37), 3'(s), 2'b00, 1'b0, 1'b0, 1'b0, "R3", 0);
    // R4: parity modes over odd and even weight data
    for (int p = 0; p < 4; p++) begin
      send(9'h107, 3'b111, 2'(p), 1'b0, 1'b0, 1'b0, "R4", 0);
      send(9'h033, 3'b000, 2'(p), 1'b0, 1'b0, 1'b0, "R4", 0);
      send(9'h0F1, 3'b010, 2'(p), 1'b1, 1'b0, 1'b0, "R4", 0);
    end
    // R5: stop bit count
    send(9'h155, 3'b011, 2'b10, 1'b1, 1'b0, 1'b0, "R5", 0);
    send(9'h0AA, 3'b001, 2'b00, 1'b1, 1'b0, 1'b0, "R5", 0);
    // R6: async with polarity set and sclk noise
    send(9'h1C3, 3'b111, 2'b11, 1'b0, 1'b0, 1'b1, "R6", 0);
    // R7: synchronous, both polarities
    send(9'h0E7, 3'b011, 2'b10, 1'b0, 1'b1, 1'b0, "R7", 0);
    send(9'h118, 3'b111, 2'b11, 1'b1, 1'b1, 1'b1, "R7", 0);
    send(9'h02D, 3'b000, 2'b00, 1'b0, 1'b1, 1'b1, "R7", 0);
    // R8: start pulses while busy
    send(9'h0C9, 3'b011, 2'b10, 1'b0, 1'b0, 1'b0, "R8", 1);
    send(9'h13A, 3'b111, 2'b11, 1'b1, 1'b1, 1'b0, "R8", 1);
    // R9: done pulse at end of frame
    send(9'h001, 3'b000, 2'b00, 1'b0, 1'b0, 1'b0, "R9", 0);
    // R10: configuration changes mid-frame
    send(9'h1B6, 3'b111, 2'b10, 1'b0, 1'b0, 1'b0, "R10", 2);
    send(9'h05B, 3'b011, 2'b11, 1'b1, 1'b1, 1'b1, "R10", 2);
    for (int k = 0; k < 20; k++)
      send(9'($urandom), 3'($urandom), 2'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), "R3", 0);
    tag = "R1";
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule